// File: doc/BRIEF.md
# Variable-Page-Size Address Translation Unit

This unit turns a 32-bit effective address into a physical address. The effective address spans a flat 4 GB space. In real mode the address goes through unchanged. In virtual mode the unit searches a small, fully associative table of translation entries. Each entry chooses its own page size from eight options, running from 1 KB up to 16 MB in steps of four. The page size sets how many upper address bits are compared and how many low bits pass straight to the physical address.

Every entry carries execute and write permissions and a 4-bit zone index. The zone index selects a 2-bit field in a zone control register, and that field can widen or narrow the page permissions. One cycle after a request, the unit reports exactly one of three outcomes: hit, miss or protection fault. Software alone loads and invalidates table entries, through a register-style write port; the hardware never chooses a victim entry. The same unit can serve an instruction-fetch path or a data path.

Top module: `vpx_xlate`

## Requirements
- R1: While `rst_ni` is low, all response outputs are 0, every table entry is invalid and the zone register is 0. After reset the unit is in real mode until `vm_en_i` is set, and a virtual-mode lookup then misses.
- R2: When `vm_en_i` is 0, a request returns in the next cycle with valid and hit set and `rsp_paddr_o` equal to the request address. The table is not consulted and no fault is raised.
- R3: In virtual mode, a request that matches no valid entry returns valid and miss set, hit and fault clear, and `rsp_paddr_o` = 0.
- R4: An entry with size code s (0 = 1 KB, up to 7 = 16 MB, page size 2^(10+2s) bytes) matches when address bits [31:10+2s] equal the same bits of its page number shifted left by 10. On a hit, `rsp_paddr_o` takes bits [31:10+2s] from the real page number shifted left by 10 and bits [9+2s:0] from the request address.
- R5: An entry whose 8-bit tag is 0 matches under any `pid_i`. An entry with any other tag matches only when the tag equals `pid_i`.
- R6: Access codes: 0 = read, 1 = write, 2 = execute, 3 = read. When the zone field defers to the page, a write to an entry with its write bit clear faults, and an execute from an entry with its execute bit clear faults. Reads are never denied by page bits.
- R7: The zone field for zone z is zone register bits [2z+1:2z]. The value 00 faults every access. The value 11 grants every access regardless of page bits. The values 01 and 10 apply the page bits. A fault reports valid and fault set, with hit and miss clear and address 0.
- R8: An invalidate of index k makes entry k miss from the next cycle on.
- R9: When a response is valid, exactly one of hit, miss and fault is set. In a cycle after no request, all four flags are 0.
- R10: A table write takes effect for lookups issued in later cycles. A lookup issued in the same cycle as a write uses the previous contents.
- R11: Writing or invalidating index k leaves every other entry unchanged. The hardware never replaces an entry on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vm_en_i | input | 1 | 1 = virtual mode, 0 = real mode |
| pid_i | input | 8 | Current process tag |
| req_valid_i | input | 1 | Lookup request |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_addr_i | input | 32 | Effective address |
| tlb_we_i | input | 1 | Write the entry at tlb_idx_i |
| tlb_idx_i | input | 4 | Entry index for a write |
| tlb_epn_i | input | 22 | Effective page number (address bits 31:10) |
| tlb_size_i | input | 3 | Page size code |
| tlb_tid_i | input | 8 | Process tag, 0 = shared |
| tlb_rpn_i | input | 22 | Real page number (address bits 31:10) |
| tlb_ex_i | input | 1 | Execute permitted |
| tlb_wr_i | input | 1 | Write permitted |
| tlb_zone_i | input | 4 | Zone index |
| tlb_inv_i | input | 1 | Invalidate the entry at tlb_inv_idx_i |
| tlb_inv_idx_i | input | 4 | Entry index for an invalidate |
| zone_we_i | input | 1 | Load the zone register |
| zone_data_i | input | 32 | Zone register value, 2 bits per zone |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Access denied |
| rsp_paddr_o | output | 32 | Physical address, 0 on miss or fault |

## Verification
Each result, whether real-mode pass-through, hit, miss or fault, is registered once. It appears after the first rising edge that follows the request. The bench drives a request on a falling edge and deasserts it on the next falling edge, where it also samples, so every check lands exactly one edge after its stimulus. Table writes, invalidates and zone loads take effect at the same single edge. The check that a concurrent lookup sees the old contents and the next lookup sees the new ones relies on this timing.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  parameter int unsigned VA_W   = 32;
  parameter int unsigned PG_LOG = 10;
  parameter int unsigned PN_W   = VA_W - PG_LOG;
  parameter int unsigned SIZE_W = 3;
  parameter int unsigned PID_W  = 8;
  parameter int unsigned ZONE_W = 4;
  parameter int unsigned ZONE_N = 1 << ZONE_W;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef struct packed {
    logic              vld;
    logic [PN_W-1:0]   epn;
    logic [SIZE_W-1:0] size;
    logic [PID_W-1:0]  tid;
    logic [PN_W-1:0]   rpn;
    logic              ex;
    logic              wr;
    logic [ZONE_W-1:0] zone;
  } tlb_ent_t;

  // 1 where a page-number bit belongs to the tag for this size
  function automatic logic [PN_W-1:0] size_mask(input logic [SIZE_W-1:0] s);
    logic [PN_W-1:0] m;
    m = '1;
    m = m << (2 * int'(s));
    return m;
  endfunction
endpackage

// File: rtl/vpx_tlb_store.sv
module vpx_tlb_store
  import vpx_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] we_idx_i,
  input  tlb_ent_t         we_ent_i,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  output tlb_ent_t         ents_o [N_ENT]
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlb_ent_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (inv_i && inv_idx_i == IDX_W'(g)) begin
        ent_q.vld <= 1'b0;  // invalidate wins over a same-index write
      end else if (we_i && we_idx_i == IDX_W'(g)) begin
        ent_q <= we_ent_i;
      end
    end
    assign ents_o[g] = ent_q;
  end
endmodule

// File: rtl/vpx_match.sv
module vpx_match
  import vpx_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  tlb_ent_t         ents_i [N_ENT],
  input  logic [PN_W-1:0]  va_pn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_ENT-1:0] hit_v;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic tag_eq, pid_ok;
    assign tag_eq = ((ents_i[g].epn ^ va_pn_i) & size_mask(ents_i[g].size)) == '0;
    assign pid_ok = (ents_i[g].tid == '0) || (ents_i[g].tid == pid_i);
    assign hit_v[g] = ents_i[g].vld && tag_eq && pid_ok;
  end

  // lowest index wins; overlap is a software error
  always_comb begin
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_v[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/vpx_zone.sv
module vpx_zone
  import vpx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2*ZONE_N-1:0] data_i,
  input  logic [ZONE_W-1:0]   sel_i,
  output logic [1:0]          field_o
);
  logic [2*ZONE_N-1:0] zone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   zone_q <= '0;
    else if (we_i) zone_q <= data_i;
  end

  assign field_o = zone_q[2*sel_i +: 2];
endmodule

// File: rtl/vpx_perm.sv
module vpx_perm
  import vpx_pkg::*;
(
  input  acc_e       acc_i,
  input  logic       ex_i,
  input  logic       wr_i,
  input  logic [1:0] zf_i,
  output logic       deny_o
);
  logic page_deny;

  assign page_deny = (acc_i == ACC_WR && !wr_i) || (acc_i == ACC_EX && !ex_i);

  always_comb begin
    unique case (zf_i)
      2'b00:   deny_o = 1'b1;
      2'b11:   deny_o = 1'b0;
      default: deny_o = page_deny;
    endcase
  end
endmodule

// File: rtl/vpx_xlate.sv
module vpx_xlate
  import vpx_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vm_en_i,
  input  logic [PID_W-1:0]    pid_i,
  input  logic                req_valid_i,
  input  logic [1:0]          req_acc_i,
  input  logic [VA_W-1:0]     req_addr_i,
  input  logic                tlb_we_i,
  input  logic [IDX_W-1:0]    tlb_idx_i,
  input  logic [PN_W-1:0]     tlb_epn_i,
  input  logic [SIZE_W-1:0]   tlb_size_i,
  input  logic [PID_W-1:0]    tlb_tid_i,
  input  logic [PN_W-1:0]     tlb_rpn_i,
  input  logic                tlb_ex_i,
  input  logic                tlb_wr_i,
  input  logic [ZONE_W-1:0]   tlb_zone_i,
  input  logic                tlb_inv_i,
  input  logic [IDX_W-1:0]    tlb_inv_idx_i,
  input  logic                zone_we_i,
  input  logic [2*ZONE_N-1:0] zone_data_i,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic                rsp_miss_o,
  output logic                rsp_fault_o,
  output logic [VA_W-1:0]     rsp_paddr_o
);
  tlb_ent_t         ents [N_ENT];
  tlb_ent_t         wr_ent;
  tlb_ent_t         sel;
  logic [PN_W-1:0]  va_pn, pa_pn, msk;
  logic             m_hit, deny;
  logic [IDX_W-1:0] m_idx;
  logic [1:0]       zf;

  assign wr_ent = '{vld: 1'b1, epn: tlb_epn_i, size: tlb_size_i, tid: tlb_tid_i,
                    rpn: tlb_rpn_i, ex: tlb_ex_i, wr: tlb_wr_i, zone: tlb_zone_i};

  vpx_tlb_store #(.N_ENT(N_ENT)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tlb_we_i),
    .we_idx_i (tlb_idx_i),
    .we_ent_i (wr_ent),
    .inv_i    (tlb_inv_i),
    .inv_idx_i(tlb_inv_idx_i),
    .ents_o   (ents)
  );

  assign va_pn = req_addr_i[VA_W-1:PG_LOG];

  vpx_match #(.N_ENT(N_ENT)) u_match (
    .ents_i (ents),
    .va_pn_i(va_pn),
    .pid_i  (pid_i),
    .hit_o  (m_hit),
    .idx_o  (m_idx)
  );

  assign sel = ents[m_idx];

  vpx_zone u_zone (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (zone_we_i),
    .data_i (zone_data_i),
    .sel_i  (sel.zone),
    .field_o(zf)
  );

  vpx_perm u_perm (
    .acc_i (acc_e'(req_acc_i)),
    .ex_i  (sel.ex),
    .wr_i  (sel.wr),
    .zf_i  (zf),
    .deny_o(deny)
  );

  assign msk   = size_mask(sel.size);
  assign pa_pn = (sel.rpn & msk) | (va_pn & ~msk);

  logic            hit_d, miss_d, fault_d;
  logic [VA_W-1:0] pa_d;

  always_comb begin
    hit_d   = 1'b0;
    miss_d  = 1'b0;
    fault_d = 1'b0;
    pa_d    = '0;
    if (req_valid_i) begin
      if (!vm_en_i) begin
        hit_d = 1'b1;
        pa_d  = req_addr_i;
      end else if (!m_hit) begin
        miss_d = 1'b1;
      end else if (deny) begin
        fault_d = 1'b1;
      end else begin
        hit_d = 1'b1;
        pa_d  = {pa_pn, req_addr_i[PG_LOG-1:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= hit_d;
      rsp_miss_o  <= miss_d;
      rsp_fault_o <= fault_d;
      rsp_paddr_o <= pa_d;
    end
  end
endmodule

// File: rtl/vpx_xlate_chk.sv
module vpx_xlate_chk
  import vpx_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            vm_en_i,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_addr_i,
  input logic            rsp_valid_o,
  input logic            rsp_hit_o,
  input logic            rsp_miss_o,
  input logic            rsp_fault_o,
  input logic [VA_W-1:0] rsp_paddr_o
);
  // R9
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_miss_o && !rsp_fault_o);

  // R2
  real_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !vm_en_i) |=> rsp_hit_o && rsp_paddr_o == $past(req_addr_i));

  // R3
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_miss_o || rsp_fault_o) |-> rsp_paddr_o == '0);

  // R4
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_paddr_o[PG_LOG-1:0] == $past(req_addr_i[PG_LOG-1:0]));

  // R7
  real_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> $past(vm_en_i));
endmodule

bind vpx_xlate vpx_xlate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vm_en_i    (vm_en_i),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_miss_o (rsp_miss_o),
  .rsp_fault_o(rsp_fault_o),
  .rsp_paddr_o(rsp_paddr_o)
);

// File: tb/sim_vpx_xlate.sv
`timescale 1ns/1ps
module sim_vpx_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vm_en_i = 1'b0;
  logic [7:0]  pid_i = '0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_acc_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        tlb_we_i = 1'b0;
  logic [3:0]  tlb_idx_i = '0;
  logic [21:0] tlb_epn_i = '0;
  logic [2:0]  tlb_size_i = '0;
  logic [7:0]  tlb_tid_i = '0;
  logic [21:0] tlb_rpn_i = '0;
  logic        tlb_ex_i = 1'b0;
  logic        tlb_wr_i = 1'b0;
  logic [3:0]  tlb_zone_i = '0;
  logic        tlb_inv_i = 1'b0;
  logic [3:0]  tlb_inv_idx_i = '0;
  logic        zone_we_i = 1'b0;
  logic [31:0] zone_data_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o;
  logic [31:0] rsp_paddr_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  vpx_xlate u0 (.*);

  // flags = {valid, hit, miss, fault}
  localparam logic [3:0] F_HIT = 4'b1100, F_MISS = 4'b1010, F_FLT = 4'b1001;

  typedef struct packed {
    logic        vm;
    logic [7:0]  pid;
    logic [1:0]  acc;
    logic [31:0] addr;
    logic [3:0]  flg;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0, 2'd0, 32'hDEAD_BEEF, F_HIT,  32'hDEAD_BEEF},
    '{1'b1, 8'd0, 2'd0, 32'h0010_0123, F_HIT,  32'h0800_0123},
    '{1'b1, 8'd0, 2'd0, 32'h0010_0400, F_MISS, 32'h0},
    '{1'b1, 8'd0, 2'd1, 32'h0010_03FF, F_HIT,  32'h0800_03FF},
    '{1'b1, 8'd0, 2'd0, 32'h40AB_CDEF, F_HIT,  32'hF0AB_CDEF},
    '{1'b1, 8'd0, 2'd2, 32'h4000_0000, F_FLT,  32'h0},
    '{1'b1, 8'd0, 2'd1, 32'h40FF_FFFF, F_HIT,  32'hF0FF_FFFF},
    '{1'b1, 8'd0, 2'd0, 32'h4100_0000, F_MISS, 32'h0},
    '{1'b1, 8'd5, 2'd1, 32'h0020_3FFC, F_HIT,  32'h0900_3FFC},
    '{1'b1, 8'd6, 2'd0, 32'h0020_0000, F_MISS, 32'h0},
    '{1'b1, 8'd9, 2'd0, 32'h8003_FFFF, F_FLT,  32'h0},
    '{1'b1, 8'd9, 2'd0, 32'h8004_0000, F_MISS, 32'h0},
    '{1'b1, 8'd5, 2'd0, 32'h0010_0010, F_HIT,  32'h0800_0010},
    '{1'b0, 8'd0, 2'd1, 32'h8000_0000, F_HIT,  32'h8000_0000},
    '{1'b1, 8'd5, 2'd2, 32'h0020_1000, F_HIT,  32'h0900_1000}
  };
  string vtag [NV] = '{"R2", "R4", "R4", "R6", "R4", "R6", "R4", "R3",
                       "R7", "R5", "R7", "R4", "R5", "R2", "R7"};

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o};
  endfunction

  task automatic look(input logic vm, input logic [7:0] pid,
                      input logic [1:0] acc, input logic [31:0] addr);
    @(negedge clk_i);
    vm_en_i = vm; pid_i = pid; req_acc_i = acc; req_addr_i = addr;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic set_ent(input logic [3:0] idx, input logic [21:0] epn,
                         input logic [2:0] sz, input logic [7:0] tid,
                         input logic [21:0] rpn, input logic ex,
                         input logic wr, input logic [3:0] zn);
    tlb_idx_i = idx; tlb_epn_i = epn; tlb_size_i = sz; tlb_tid_i = tid;
    tlb_rpn_i = rpn; tlb_ex_i = ex; tlb_wr_i = wr; tlb_zone_i = zn;
  endtask

  task automatic put_ent(input logic [3:0] idx, input logic [21:0] epn,
                         input logic [2:0] sz, input logic [7:0] tid,
                         input logic [21:0] rpn, input logic ex,
                         input logic wr, input logic [3:0] zn);
    @(negedge clk_i);
    set_ent(idx, epn, sz, tid, rpn, ex, wr, zn);
    tlb_we_i = 1'b1;
    @(negedge clk_i);
    tlb_we_i = 1'b0;
  endtask

  task automatic put_zone(input logic [31:0] z);
    @(negedge clk_i);
    zone_data_i = z; zone_we_i = 1'b1;
    @(negedge clk_i);
    zone_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog got hang exp done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", "reset flags", 32'(flags()), 32'h0);
    check("R1", "reset paddr", rsp_paddr_o, 32'h0);
    rst_ni = 1'b1;

    // zone1=01 zone2=10 zone3=11 zone4=00
    put_zone(32'h0000_00E4);
    put_ent(4'd0, 22'h000400, 3'd0, 8'd0, 22'h020000, 1'b1, 1'b1, 4'd1);
    put_ent(4'd1, 22'h100000, 3'd7, 8'd0, 22'h3C0000, 1'b0, 1'b1, 4'd2);
    put_ent(4'd2, 22'h000800, 3'd2, 8'd5, 22'h024000, 1'b1, 1'b0, 4'd3);
    put_ent(4'd5, 22'h200000, 3'd4, 8'd9, 22'h040100, 1'b1, 1'b0, 4'd4);

    for (int i = 0; i < NV; i++) begin
      look(VECS[i].vm, VECS[i].pid, VECS[i].acc, VECS[i].addr);
      check(vtag[i], $sformatf("vec %0d flags", i), 32'(flags()), 32'(VECS[i].flg));
      check(vtag[i], $sformatf("vec %0d paddr", i), rsp_paddr_o, VECS[i].pa);
    end

    // R9 idle cycle clears response
    @(negedge clk_i);
    check("R9", "idle flags", 32'(flags()), 32'h0);

    // R8 invalidate entry 1
    @(negedge clk_i);
    tlb_inv_idx_i = 4'd1; tlb_inv_i = 1'b1;
    @(negedge clk_i);
    tlb_inv_i = 1'b0;
    look(1'b1, 8'd0, 2'd0, 32'h40AB_CDEF);
    check("R8", "inv flags", 32'(flags()), 32'(F_MISS));
    // R11 neighbour untouched
    look(1'b1, 8'd0, 2'd0, 32'h0010_0123);
    check("R11", "neighbour paddr", rsp_paddr_o, 32'h0800_0123);

    // R10 write and lookup in the same cycle
    @(negedge clk_i);
    set_ent(4'd0, 22'h000400, 3'd0, 8'd0, 22'h030000, 1'b1, 1'b1, 4'd1);
    tlb_we_i = 1'b1;
    vm_en_i = 1'b1; pid_i = 8'd0; req_acc_i = 2'd0;
    req_addr_i = 32'h0010_0123; req_valid_i = 1'b1;
    @(negedge clk_i);
    tlb_we_i = 1'b0; req_valid_i = 1'b0;
    check("R10", "same-cycle old paddr", rsp_paddr_o, 32'h0800_0123);
    look(1'b1, 8'd0, 2'd0, 32'h0010_0123);
    check("R10", "next new paddr", rsp_paddr_o, 32'h0C00_0123);
    look(1'b1, 8'd5, 2'd0, 32'h0020_0000);
    check("R11", "entry 2 kept", rsp_paddr_o, 32'h0900_0000);

    // R7 reopen zone 4 with full grant: write to read-only page passes
    put_zone(32'h0000_03E4);
    look(1'b1, 8'd9, 2'd1, 32'h8000_0004);
    check("R7", "zone 11 flags", 32'(flags()), 32'(F_HIT));
    check("R7", "zone 11 paddr", rsp_paddr_o, 32'h1004_0004);
    // R6 zone 01 applies page bits; access code 3 acts as read
    look(1'b1, 8'd0, 2'd3, 32'h0010_0200);
    check("R6", "code 3 read", 32'(flags()), 32'(F_HIT));

    // R1 asynchronous reset clears the table
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", "async reset flags", 32'(flags()), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    look(1'b1, 8'd0, 2'd0, 32'h0010_0123);
    check("R1", "table cleared", 32'(flags()), 32'(F_MISS));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule